// File: doc/BRIEF.md
# Processor Mode-Control Register Unit

This block keeps the mode-control state of a processor core: a mode register, a translation-root register, an extension-control register, an extended-mode register, and the instruction pointer and code-width state that mode changes touch. From these it maintains a packed word of shadow flags. Downstream logic reads these flags every cycle instead of decoding the registers again. A single write port picks a target with a 3-bit select and carries the new value. A capability vector says which optional features the core has. Writes that try to enable an absent feature are masked before they are stored.

Writes are evaluated for side effects. The unit requests a one-cycle translation-cache flush only when a bit that changes address translation actually changes. It activates or deactivates the wide (long) addressing mode when paging is switched on or off. An entry into wide mode that is not legal is abandoned, and a one-cycle fault pulse reports it. All outputs are registered and show the effect of a write in the cycle after the clock edge that accepts it. At most one write is accepted per cycle.

Top module: `ctlreg_unit`

## Requirements
- R1: After reset every register and every flag reads 0, except mode bit 4, which reads 1. The flush and fault outputs are 0.
- R2: Mode bit 4 always reads 1, whatever value was written.
- R3: A write with select 0 (mode register) raises flush_o for exactly the one cycle after the write. It does so only if bit 0 (protection enable), bit 16 (write protect) or bit 31 (paging enable) of the new value differs from the stored value. This holds even when the write is abandoned under R7.
- R4: After an accepted mode write, flag bit 0 equals mode bit 0. If that bit was written 0, flag bit 1 (segment-base add) becomes 1; otherwise flag bit 1 keeps its value.
- R5: After an accepted mode write, flag bits 4..2 equal mode bits 3..1.
- R6: A mode write that turns bit 31 on while it was off is an entry into wide mode when extended-mode bit 8 (wide enable) is 1. If extension bit 5 (wide address tables) is 1, the entry is accepted: extended-mode bit 10 (wide active) and flag bit 5 become 1.
- R7: If such an entry finds extension bit 5 at 0, the mode register, the extended-mode register and the flags stay unchanged, and fault_o pulses for one cycle.
- R8: A mode write that turns bit 31 off while extended-mode bit 10 is 1 clears that bit, flag bit 5 and flag bit 6 (64-bit code), and zeroes the upper 32 bits of the instruction pointer.
- R9: A write with select 1 loads the translation root from all data bits. It raises flush_o for one cycle if and only if mode bit 31 is 1.
- R10: A write with select 2 (extension register) raises flush_o for one cycle if and only if any of bits 4, 5, 7, 12, 20 or 21 of the stored value changes. The comparison uses the value after R11 filtering.
- R11: On an extension write, a missing capability forces its bit to 0. The pairs are cap_i[0] to bit 9, cap_i[1] to bit 21, cap_i[2] to bit 11, cap_i[3] to bit 22 and cap_i[4] to bit 24. Flag bits 8, 9 and 10 then equal the stored bits 9, 21 and 11.
- R12: A write with select 3 stores the low 32 data bits in the extended-mode register. Flag bit 5 becomes data bit 10 and flag bit 7 (secure-VM enable) becomes data bit 12.
- R13: Select 4 loads the instruction pointer from all data bits. Select 5 loads flag bit 6 from data bit 0. Selects 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request for this cycle |
| wr_sel_i | input | 3 | Write target (0 mode, 1 root, 2 extension, 3 extended mode, 4 instruction pointer, 5 code width) |
| wr_data_i | input | 64 | Write value |
| cap_i | input | 5 | Feature capabilities, 1 = present |
| mode_o | output | 32 | Mode register |
| root_o | output | 64 | Translation root register |
| ext_o | output | 32 | Extension-control register |
| xmode_o | output | 32 | Extended-mode register |
| ip_o | output | 64 | Instruction pointer |
| flags_o | output | 16 | Shadow flags |
| flush_o | output | 1 | One-cycle translation-cache flush request |
| fault_o | output | 1 | One-cycle pulse on an abandoned wide-mode entry |

## Verification
The bench sweeps every combination of the six mode bits that matter, in rising and then falling order. A design that compared all bits would flush on a change of bit 1, and one that compared against the written value instead of the stored one would miss the second flush. Every capability vector is paired with several extension patterns, which catches a swapped capability-to-bit pair and a flush decided on the unfiltered value. The wide-mode sequence covers an entry with the address-table bit clear, then a legal entry, then an exit. A design that stored the mode value on the rejected entry, kept the upper instruction-pointer half, or left the 64-bit code flag set would show it at the outputs.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    // write targets
    typedef enum logic [2:0] {
        SEL_MODE  = 3'd0,
        SEL_ROOT  = 3'd1,
        SEL_EXT   = 3'd2,
        SEL_XMODE = 3'd3,
        SEL_IP    = 3'd4,
        SEL_CSW   = 3'd5
    } wr_sel_e;

    // mode register bits
    localparam int MB_PROT = 0;
    localparam int MB_MP   = 1;   // first of three coprocessor bits
    localparam int MB_EXT  = 4;
    localparam int MB_WP   = 16;
    localparam int MB_PAGE = 31;
    localparam logic [31:0] MODE_FLUSH_MASK = 32'h8001_0001;

    // extension register bits
    localparam int XB_WIDE = 5;
    localparam logic [31:0] EXT_FLUSH_MASK = 32'h0030_10B0;

    // extended-mode register bits
    localparam int EB_LME = 8;
    localparam int EB_LMA = 10;
    localparam int EB_SVM = 12;

    // capability inputs and the extension bits they gate
    localparam int NCAP = 5;
    localparam int CAP_POS [NCAP] = '{9, 21, 11, 22, 24};

    // shadow flag bits
    localparam int FL_PROT   = 0;
    localparam int FL_SEGADD = 1;
    localparam int FL_FPU    = 2;   // three bits
    localparam int FL_LMA    = 5;
    localparam int FL_CS64   = 6;
    localparam int FL_SVM    = 7;
    localparam int FL_FXS    = 8;
    localparam int FL_SMAP   = 9;
    localparam int FL_UMIP   = 10;

endpackage

// File: rtl/ctlreg_mode_eval.sv
module ctlreg_mode_eval
    import ctlreg_pkg::*;
#(
    parameter int CREG_W = 32
) (
    input  logic [CREG_W-1:0] cur_i,
    input  logic [CREG_W-1:0] wdata_i,
    input  logic              lm_en_i,
    input  logic              lm_act_i,
    input  logic              wide_i,
    output logic [CREG_W-1:0] next_o,
    output logic              flush_o,
    output logic              enter_o,
    output logic              reject_o,
    output logic              leave_o
);
    localparam logic [CREG_W-1:0] FMASK = CREG_W'(MODE_FLUSH_MASK);

    logic pg_rise;

    always_comb begin
        next_o         = wdata_i;
        next_o[MB_EXT] = 1'b1;
        flush_o  = |((cur_i ^ next_o) & FMASK);
        pg_rise  = !cur_i[MB_PAGE] && next_o[MB_PAGE] && lm_en_i;
        enter_o  = pg_rise && wide_i;
        reject_o = pg_rise && !wide_i;
        leave_o  = cur_i[MB_PAGE] && !next_o[MB_PAGE] && lm_act_i;
    end
endmodule

// File: rtl/ctlreg_ext_filter.sv
module ctlreg_ext_filter
    import ctlreg_pkg::*;
#(
    parameter int CREG_W = 32
) (
    input  logic [CREG_W-1:0] cur_i,
    input  logic [CREG_W-1:0] wdata_i,
    input  logic [NCAP-1:0]   cap_i,
    output logic [CREG_W-1:0] filt_o,
    output logic              flush_o
);
    localparam logic [CREG_W-1:0] FMASK = CREG_W'(EXT_FLUSH_MASK);

    logic [CREG_W-1:0] kill;

    always_comb begin
        kill = '0;
        for (int g = 0; g < NCAP; g++) begin
            if (!cap_i[g]) kill[CAP_POS[g]] = 1'b1;
        end
        filt_o  = wdata_i & ~kill;
        flush_o = |((filt_o ^ cur_i) & FMASK);
    end
endmodule

// File: rtl/ctlreg_unit.sv
module ctlreg_unit
    import ctlreg_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int CREG_W = 32,
    parameter int FLAG_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [XLEN-1:0]   wr_data_i,
    input  logic [NCAP-1:0]   cap_i,
    output logic [CREG_W-1:0] mode_o,
    output logic [XLEN-1:0]   root_o,
    output logic [CREG_W-1:0] ext_o,
    output logic [CREG_W-1:0] xmode_o,
    output logic [XLEN-1:0]   ip_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              flush_o,
    output logic              fault_o
);
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        logic [CREG_W-1:0] mode;
        logic [XLEN-1:0]   root;
        logic [CREG_W-1:0] ext;
        logic [CREG_W-1:0] xm;
        logic [XLEN-1:0]   ip;
        logic [FLAG_W-1:0] fl;
        logic              flush;
        logic              fault;
    } state_t;

    state_t st_d, st_q;

    logic [CREG_W-1:0] mode_next, ext_filt;
    logic              mode_flush, mode_enter, mode_reject, mode_leave;
    logic              ext_flush;

    ctlreg_mode_eval #(.CREG_W(CREG_W)) u_mode (
        .cur_i    (st_q.mode),
        .wdata_i  (wr_data_i[CREG_W-1:0]),
        .lm_en_i  (st_q.xm[EB_LME]),
        .lm_act_i (st_q.xm[EB_LMA]),
        .wide_i   (st_q.ext[XB_WIDE]),
        .next_o   (mode_next),
        .flush_o  (mode_flush),
        .enter_o  (mode_enter),
        .reject_o (mode_reject),
        .leave_o  (mode_leave)
    );

    ctlreg_ext_filter #(.CREG_W(CREG_W)) u_ext (
        .cur_i   (st_q.ext),
        .wdata_i (wr_data_i[CREG_W-1:0]),
        .cap_i   (cap_i),
        .filt_o  (ext_filt),
        .flush_o (ext_flush)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        st_d.fault = 1'b0;
        if (wr_en_i) begin
            case (wr_sel_i)
                SEL_MODE: begin
                    st_d.flush = mode_flush;
                    if (mode_reject) begin
                        st_d.fault = 1'b1;
                    end else begin
                        st_d.mode = mode_next;
                        if (mode_enter) begin
                            st_d.xm[EB_LMA] = 1'b1;
                            st_d.fl[FL_LMA] = 1'b1;
                        end
                        if (mode_leave) begin
                            st_d.xm[EB_LMA]       = 1'b0;
                            st_d.fl[FL_LMA]       = 1'b0;
                            st_d.fl[FL_CS64]      = 1'b0;
                            st_d.ip[XLEN-1:HALF]  = '0;
                        end
                        st_d.fl[FL_PROT] = mode_next[MB_PROT];
                        if (!mode_next[MB_PROT]) st_d.fl[FL_SEGADD] = 1'b1;
                        st_d.fl[FL_FPU +: 3] = mode_next[MB_MP +: 3];
                    end
                end
                SEL_ROOT: begin
                    st_d.root  = wr_data_i;
                    st_d.flush = st_q.mode[MB_PAGE];
                end
                SEL_EXT: begin
                    st_d.ext         = ext_filt;
                    st_d.flush       = ext_flush;
                    st_d.fl[FL_FXS]  = ext_filt[CAP_POS[0]];
                    st_d.fl[FL_SMAP] = ext_filt[CAP_POS[1]];
                    st_d.fl[FL_UMIP] = ext_filt[CAP_POS[2]];
                end
                SEL_XMODE: begin
                    st_d.xm         = wr_data_i[CREG_W-1:0];
                    st_d.fl[FL_LMA] = wr_data_i[EB_LMA];
                    st_d.fl[FL_SVM] = wr_data_i[EB_SVM];
                end
                SEL_IP: begin
                    st_d.ip = wr_data_i;
                end
                SEL_CSW: begin
                    st_d.fl[FL_CS64] = wr_data_i[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q              <= '0;
            st_q.mode[MB_EXT] <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign root_o  = st_q.root;
    assign ext_o   = st_q.ext;
    assign xmode_o = st_q.xm;
    assign ip_o    = st_q.ip;
    assign flags_o = st_q.fl;
    assign flush_o = st_q.flush;
    assign fault_o = st_q.fault;
endmodule

// File: rtl/ctlreg_unit_chk.sv
module ctlreg_unit_chk
    import ctlreg_pkg::*;
#(
    parameter int CREG_W = 32,
    parameter int FLAG_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [2:0]        wr_sel_i,
    input logic [CREG_W-1:0] mode_o,
    input logic [CREG_W-1:0] ext_o,
    input logic [CREG_W-1:0] xmode_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic              flush_o,
    input logic              fault_o
);
    logic past_ok;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) past_ok <= 1'b0;
        else         past_ok <= 1'b1;
    end

    a_r2_ext_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_o[MB_EXT]);

    a_r4_prot_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_o[FL_PROT] == mode_o[MB_PROT]);

    a_r5_fpu_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_o[FL_FPU +: 3] == mode_o[MB_MP +: 3]);

    a_r6_wide_flag_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_o[FL_LMA] == xmode_o[EB_LMA]);

    a_r7_reject_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && fault_o) |-> $stable(mode_o));

    a_r3_flush_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && flush_o) |-> $past(wr_en_i));

    a_r9_root_no_flush_unpaged: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && $past(wr_en_i && wr_sel_i == 3'd1 && !mode_o[MB_PAGE])) |-> !flush_o);

    a_r11_smap_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_o[FL_SMAP] == ext_o[CAP_POS[1]]);
endmodule

bind ctlreg_unit ctlreg_unit_chk #(.CREG_W(CREG_W), .FLAG_W(FLAG_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .mode_o   (mode_o),
    .ext_o    (ext_o),
    .xmode_o  (xmode_o),
    .flags_o  (flags_o),
    .flush_o  (flush_o),
    .fault_o  (fault_o)
);

// File: tb/sim_ctlreg_unit.sv
module sim_ctlreg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [63:0] wr_data = '0;
    logic [4:0]  cap = 5'h1F;
    logic [31:0] mode, ext, xmode;
    logic [63:0] root, ip;
    logic [15:0] flags;
    logic        flush, fault;

    always #2 clk = ~clk;

    ctlreg_unit u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .cap_i(cap), .mode_o(mode), .root_o(root),
        .ext_o(ext), .xmode_o(xmode), .ip_o(ip), .flags_o(flags),
        .flush_o(flush), .fault_o(fault)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_mode, m_ext, m_xm;
    logic [63:0] m_root, m_ip;
    logic [15:0] m_fl;
    logic        m_flush, m_fault;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [2:0] s, input logic [63:0] d);
        logic [31:0] v, kill;
        logic go_in, go_out;
        m_flush = 0;
        m_fault = 0;
        case (s)
            3'd0: begin
                v = d[31:0] | 32'h10;
                m_flush = ((v ^ m_mode) & 32'h8001_0001) != 0;
                go_in  = !m_mode[31] && v[31] && m_xm[8];
                go_out = m_mode[31] && !v[31] && m_xm[10];
                if (go_in && !m_ext[5]) m_fault = 1;
                else begin
                    if (go_in) begin m_xm[10] = 1; m_fl[5] = 1; end
                    if (go_out) begin
                        m_xm[10] = 0; m_fl[5] = 0; m_fl[6] = 0;
                        m_ip = {32'h0, m_ip[31:0]};
                    end
                    m_mode = v;
                    m_fl[0] = v[0];
                    if (v[0] == 0) m_fl[1] = 1;
                    m_fl[4:2] = v[3:1];
                end
            end
            3'd1: begin m_root = d; m_flush = m_mode[31]; end
            3'd2: begin
                kill = 0;
                if (!cap[0]) kill |= 32'h1 << 9;
                if (!cap[1]) kill |= 32'h1 << 21;
                if (!cap[2]) kill |= 32'h1 << 11;
                if (!cap[3]) kill |= 32'h1 << 22;
                if (!cap[4]) kill |= 32'h1 << 24;
                v = d[31:0] & ~kill;
                m_flush = ((v ^ m_ext) & 32'h0030_10B0) != 0;
                m_ext = v;
                m_fl[8] = v[9]; m_fl[9] = v[21]; m_fl[10] = v[11];
            end
            3'd3: begin m_xm = d[31:0]; m_fl[5] = d[10]; m_fl[7] = d[12]; end
            3'd4: m_ip = d;
            3'd5: m_fl[6] = d[0];
            default: ;
        endcase
    endtask

    task automatic compare(input string tag);
        chk({tag, " mode"}, 64'(mode), 64'(m_mode));
        chk({tag, " root"}, root, m_root);
        chk({tag, " ext"}, 64'(ext), 64'(m_ext));
        chk({tag, " xmode"}, 64'(xmode), 64'(m_xm));
        chk({tag, " ip"}, ip, m_ip);
        chk({tag, " flags"}, 64'(flags), 64'(m_fl));
        chk({tag, " flush"}, 64'(flush), 64'(m_flush));
        chk({tag, " fault"}, 64'(fault), 64'(m_fault));
    endtask

    task automatic wr(input logic [2:0] s, input logic [63:0] d, input string tag);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d;
        model(s, d);
        @(negedge clk);
        wr_en = 0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        chk({tag, " pulse end flush"}, 64'(flush), 64'd0);
        chk({tag, " pulse end fault"}, 64'(fault), 64'd0);
    endtask

    function automatic logic [31:0] mode_pat(input int i);
        logic [31:0] r;
        r = 32'h0;
        r[3:0] = i[3:0];
        r[16]  = i[4];
        r[31]  = i[5];
        return r | 32'h0000_0F40;   // unmonitored bits set as noise
    endfunction

    initial begin
        m_mode = 32'h10; m_root = 0; m_ext = 0; m_xm = 0; m_ip = 0; m_fl = 0;
        m_flush = 0; m_fault = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R1 reset");

        // mode sweep, both directions (R2 R3 R4 R5)
        for (int i = 0; i < 64; i++) wr(3'd0, 64'(mode_pat(i)), "R3 R4 R5 mode up");
        idle("R3");
        for (int i = 63; i >= 0; i--) wr(3'd0, 64'(mode_pat(i)), "R2 R5 mode down");
        wr(3'd0, 64'h0000_0002, "R4 segadd held");
        wr(3'd0, 64'h0000_0003, "R4 segadd keep");

        // root writes with paging off, then on (R9)
        wr(3'd1, 64'h0123_4567_89AB_CDEF, "R9 root unpaged");
        wr(3'd0, 64'h8000_0001, "R3 paging on");
        wr(3'd1, 64'hFEDC_BA98_7654_3210, "R9 root paged");
        idle("R9");
        wr(3'd0, 64'h0000_0001, "R3 paging off");

        // extension sweep over every capability vector (R10 R11)
        for (int c = 0; c < 32; c++) begin
            cap = 5'(c);
            for (int k = 0; k < 8; k++) begin
                logic [31:0] p;
                p = (32'(k) * 32'h9E37_79B9) ^ (32'(c) * 32'h0101_0101);
                if (k[0]) p = p | 32'h0160_0A00;
                wr(3'd2, 64'(p), "R10 R11 ext");
            end
        end
        cap = 5'h1F;
        wr(3'd2, 64'h0000_0000, "R10 ext clear");
        wr(3'd2, 64'h0000_0000, "R10 ext same");

        // extended-mode sweep (R12)
        for (int j = 0; j < 8; j++) begin
            logic [31:0] p;
            p = 32'h0000_0001;
            p[8] = j[0]; p[10] = j[1]; p[12] = j[2];
            wr(3'd3, 64'hFFFF_0000_0000_0000 | 64'(p), "R12 xmode");
        end

        // wide-mode entry rejected, accepted, exit (R6 R7 R8 R13)
        wr(3'd0, 64'h0000_0000, "R3 base");
        wr(3'd3, 64'h0000_0100, "R12 enable wide");
        wr(3'd2, 64'h0000_0000, "R10 tables off");
        wr(3'd0, 64'h8000_0001, "R7 rejected entry");
        idle("R7");
        wr(3'd2, 64'h0000_0020, "R10 tables on");
        wr(3'd4, 64'hFFFF_FFFF_1234_5678, "R13 ip load");
        wr(3'd5, 64'h1, "R13 code width");
        wr(3'd0, 64'h8000_0001, "R6 entry");
        wr(3'd0, 64'h0000_0001, "R8 exit");
        wr(3'd0, 64'h0000_0001, "R8 no repeat");

        // ignored selects (R13)
        wr(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, "R13 sel6");
        wr(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, "R13 sel7");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule